// File: doc/BRIEF.md
# Three-Read-Port Register Bank with Hi/Lo Pair

This block is the architectural register storage of a small 32-bit RISC datapath. It holds 32 registers of 32 bits. Three read ports can each look at any register at the same time, and their outputs follow the stored contents with no clock involved. The operand-fetch logic can therefore present three register numbers and use the data within the same cycle.

Storage changes only on the falling clock edge. A general write port stores one word, taken either from the ALU result or from a data-memory load, into any register. A second, wider port stores a 64-bit long-multiply product into the top two registers. Register 30 takes the upper half and serves as Hi. Register 31 takes the lower half and serves as Lo. If both ports hit the same register on the same edge, the product write is the one kept.

Top module: `tri_read_regbank`

## Requirements
- R1: When `rst` is 1 at a falling clock edge, all 32 registers become zero, and the write inputs have no effect on that edge.
- R2: Each of the three read ports outputs the register selected by its own 5-bit address. The output is combinational, and the three ports work independently of one another.
- R3: A general write changes storage only at a falling clock edge where `wr_en` is 1. With `wr_en` and `mul_en` both 0, no register changes.
- R4: The general write data is `mem_rdata` when `wr_sel_mem` is 1 and `alu_result` when `wr_sel_mem` is 0.
- R5: When `mul_en` is 1 at a falling edge, `mul_result[63:32]` is stored in register 30 (Hi) and `mul_result[31:0]` is stored in register 31 (Lo).
- R6: If a general write targets register 30 or 31 on the same edge as a product write, that register takes the product half. A general write to any other register on that edge still takes effect.
- R7: When a register is read and written in the same cycle, the read returns the old value until the falling edge and the new value after it.
- R8: With `mul_en` at 0, the general port can write every register from 0 to 31, including Hi and Lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_addr_c | input | 5 | Register number for read port C |
| rd_data_a | output | 32 | Contents of the register selected on port A |
| rd_data_b | output | 32 | Contents of the register selected on port B |
| rd_data_c | output | 32 | Contents of the register selected on port C |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 5 | General write register number |
| wr_sel_mem | input | 1 | 1 selects memory load data, 0 selects ALU result |
| alu_result | input | 32 | ALU result candidate for the general write |
| mem_rdata | input | 32 | Data-memory load candidate for the general write |
| mul_en | input | 1 | Hi/Lo product write enable |
| mul_result | input | 64 | Long-multiply product; upper half to Hi, lower half to Lo |

## Verification
Reads are combinational, so a bad stored word shows on a read port as soon as that register is addressed, right after the falling edge that wrote it. A write sent to the wrong register, or one that took the wrong data source, stays hidden until that register is read. For this reason the bench reads back every register number and checks the neighbours of each write target. A broken collision rule appears only on the edge where both ports are active. It is visible at once on Hi or Lo, together with the general write to a non-reserved register that must survive on that same edge.

// File: rtl/tri_read_regbank.sv
module tri_read_regbank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int HI_IDX = 30,
  parameter int LO_IDX = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   rd_addr_a,
  input  logic [ADDR_W-1:0]   rd_addr_b,
  input  logic [ADDR_W-1:0]   rd_addr_c,
  output logic [DATA_W-1:0]   rd_data_a,
  output logic [DATA_W-1:0]   rd_data_b,
  output logic [DATA_W-1:0]   rd_data_c,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_sel_mem,
  input  logic [DATA_W-1:0]   alu_result,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mul_en,
  input  logic [2*DATA_W-1:0] mul_result
);
  localparam int NREGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] wdata;

  assign wdata = wr_sel_mem ? mem_rdata : alu_result;

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];
  assign rd_data_c = regs[rd_addr_c];

  // Product write is placed last so it overrides a general write to Hi/Lo.
  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (wr_en) regs[wr_addr] <= wdata;
      if (mul_en) begin
        regs[HI_IDX] <= mul_result[2*DATA_W-1:DATA_W];
        regs[LO_IDX] <= mul_result[DATA_W-1:0];
      end
    end
  end

  // R5 R6
  hilo_load_chk: assert property (@(negedge clk) disable iff (rst)
    mul_en |=> (regs[HI_IDX] == $past(mul_result[2*DATA_W-1:DATA_W]))
            && (regs[LO_IDX] == $past(mul_result[DATA_W-1:0])));

  // R4
  mem_source_chk: assert property (@(negedge clk) disable iff (rst)
    (wr_en && wr_sel_mem && !mul_en) |=> regs[$past(wr_addr)] == $past(mem_rdata));

  // R4
  alu_source_chk: assert property (@(negedge clk) disable iff (rst)
    (wr_en && !wr_sel_mem && !mul_en) |=> regs[$past(wr_addr)] == $past(alu_result));

  // R3
  hold_chk: assert property (@(negedge clk) disable iff (rst)
    (!wr_en && !mul_en) |=> regs[$past(rd_addr_a)] == $past(rd_data_a));
endmodule

// File: tb/test_tri_read_regbank.sv
module test_tri_read_regbank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0;
  logic [31:0] rd_data_a, rd_data_b, rd_data_c;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic        wr_sel_mem = 1'b0;
  logic [31:0] alu_result = '0, mem_rdata = '0;
  logic        mul_en = 1'b0;
  logic [63:0] mul_result = '0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  tri_read_regbank i_tri_read_regbank (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_addr_c(rd_addr_c),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel_mem(wr_sel_mem),
    .alu_result(alu_result), .mem_rdata(mem_rdata),
    .mul_en(mul_en), .mul_result(mul_result)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hC3A5_0000 ^ (i * 32'h0101_0111);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Drive at the rising edge, let the falling edge commit, settle.
  task automatic gen_write(input logic [4:0] a, input logic sel,
                           input logic [31:0] alu, input logic [31:0] mem);
    @(posedge clk);
    wr_en = 1'b1; wr_addr = a; wr_sel_mem = sel; alu_result = alu; mem_rdata = mem;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic read3(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
    rd_addr_a = a; rd_addr_b = b; rd_addr_c = c;
    #1;
  endtask

  task automatic t_fill_all;
    for (int i = 0; i < 32; i++) gen_write(5'(i), 1'b0, pat(i), ~pat(i));
    for (int i = 0; i < 32; i++) begin
      read3(5'(i), 5'(31 - i), 5'((i + 7) % 32));
      chk("R8 port A", rd_data_a, pat(i));
      chk("R2 port B", rd_data_b, pat(31 - i));
      chk("R2 port C", rd_data_c, pat((i + 7) % 32));
    end
  endtask

  task automatic t_source_select;
    gen_write(5'd5, 1'b1, 32'h1111_1111, 32'hDEAD_BEEF);
    read3(5'd5, 5'd4, 5'd6);
    chk("R4 mem selected", rd_data_a, 32'hDEAD_BEEF);
    chk("R4 neighbour low", rd_data_b, pat(4));
    chk("R4 neighbour high", rd_data_c, pat(6));
    gen_write(5'd5, 1'b0, 32'h0BAD_F00D, 32'h2222_2222);
    read3(5'd5, 5'd5, 5'd5);
    chk("R4 alu selected", rd_data_a, 32'h0BAD_F00D);
  endtask

  task automatic t_no_enable;
    @(posedge clk);
    wr_en = 1'b0; wr_addr = 5'd9; wr_sel_mem = 1'b0; alu_result = 32'hFFFF_0000;
    @(negedge clk); #1;
    @(negedge clk); #1;
    read3(5'd9, 5'd0, 5'd29);
    chk("R3 disabled write ignored", rd_data_a, pat(9));
    chk("R3 reg0 unchanged", rd_data_b, pat(0));
    chk("R3 reg29 unchanged", rd_data_c, pat(29));
  endtask

  task automatic t_hilo;
    @(posedge clk);
    mul_en = 1'b1; mul_result = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); #1;
    mul_en = 1'b0;
    read3(5'd30, 5'd31, 5'd29);
    chk("R5 hi half", rd_data_a, 32'h0123_4567);
    chk("R5 lo half", rd_data_b, 32'h89AB_CDEF);
    chk("R5 reg29 untouched", rd_data_c, pat(29));
  endtask

  task automatic t_collision;
    @(posedge clk);
    mul_en = 1'b1; mul_result = 64'hAAAA_0001_5555_0002;
    wr_en = 1'b1; wr_addr = 5'd30; wr_sel_mem = 1'b0; alu_result = 32'h7777_7777;
    @(negedge clk); #1;
    read3(5'd30, 5'd31, 5'd30);
    chk("R6 hi wins over general", rd_data_a, 32'hAAAA_0001);
    chk("R6 lo written", rd_data_b, 32'h5555_0002);
    @(posedge clk);
    mul_result = 64'hBBBB_0003_CCCC_0004;
    wr_addr = 5'd31; alu_result = 32'h6666_6666;
    @(negedge clk); #1;
    read3(5'd31, 5'd30, 5'd12);
    chk("R6 lo wins over general", rd_data_a, 32'hCCCC_0004);
    chk("R6 hi written", rd_data_b, 32'hBBBB_0003);
    @(posedge clk);
    mul_result = 64'hDDDD_0005_EEEE_0006;
    wr_addr = 5'd12; alu_result = 32'h1234_ABCD;
    @(negedge clk); #1;
    wr_en = 1'b0; mul_en = 1'b0;
    read3(5'd12, 5'd30, 5'd31);
    chk("R6 other-register general write kept", rd_data_a, 32'h1234_ABCD);
    chk("R6 hi with parallel write", rd_data_b, 32'hDDDD_0005);
    chk("R6 lo with parallel write", rd_data_c, 32'hEEEE_0006);
  endtask

  task automatic t_read_during_write;
    @(posedge clk);
    rd_addr_a = 5'd20; rd_addr_b = 5'd20; rd_addr_c = 5'd21;
    wr_en = 1'b1; wr_addr = 5'd20; wr_sel_mem = 1'b1; mem_rdata = 32'h5A5A_A5A5;
    #1;
    chk("R7 old value before edge", rd_data_a, pat(20));
    @(negedge clk); #1;
    wr_en = 1'b0;
    chk("R7 new value after edge", rd_data_b, 32'h5A5A_A5A5);
    chk("R7 neighbour", rd_data_c, pat(21));
  endtask

  task automatic t_reset;
    @(posedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd3; alu_result = 32'hFACE_FACE; wr_sel_mem = 1'b0;
    mul_en = 1'b1; mul_result = '1;
    @(negedge clk); #1;
    rst = 1'b0; wr_en = 1'b0; mul_en = 1'b0;
    for (int i = 0; i < 32; i += 3) begin
      read3(5'(i), 5'((i + 1) % 32), 5'((i + 2) % 32));
      chk("R1 cleared A", rd_data_a, '0);
      chk("R1 cleared B", rd_data_b, '0);
      chk("R1 cleared C", rd_data_c, '0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    rst = 1'b0;
    read3(5'd0, 5'd17, 5'd31);
    chk("R1 reset state A", rd_data_a, '0);
    chk("R1 reset state B", rd_data_b, '0);
    chk("R1 reset state C", rd_data_c, '0);
    t_fill_all();
    t_source_select();
    t_no_enable();
    t_hilo();
    t_collision();
    t_read_during_write();
    t_reset();
    finish_run();
  end
endmodule